// File: doc/BRIEF.md
# Memory-Image Register Test Engine

This block is a hardware sequencer that runs a register-level conformance test against a device under test. It reads a nested test image from a word-addressed synchronous memory. The image has two parts: a stimulus part, which holds what gets written, and a check part, which holds expected read-back values. Each part is a tree linked by pointers. At the top is a list of blocks. Each block holds a list of sequences. Each sequence covers a run of consecutive device registers and carries one value word and one mask word per register.

Software places both image parts in memory, sets the two base addresses and pulses `start`. The engine takes one stimulus block and then one check block, and repeats this until both parts are used up. For each stimulus register it reads the current contents and writes back a per-bit merge with the image value. For each check register it reads the register and compares it bit by bit under the mask. When it finishes it raises `done`. It also reports a sticky pass/fail result together with the location and bit pattern of the first mismatch.

Top module: `reg_image_tester`

## Requirements
- R1: After reset, and whenever no run is active, `busy`, `done` and `fail` are low, except that `done` and `fail` keep their end-of-run values. No memory read and no register access is issued while `busy` is low.
- R2: Each image part starts at its base address. Word 0 of the part holds the block count NB. Words 1..NB hold the block pointers. Word NB+1 holds an end pointer. Every pointer is a word offset from the base of its own part. Block b ends where the pointer at word b+2 points.
- R3: A block starts with its sequence count NS, followed by NS sequence pointers. A sequence starts with its start-register word, which supplies the low register-address bits. The value words follow, then the mask words. The register count N is half the number of words between the start-register word and the following sequence pointer, or the block end for the last sequence. Register k is at start address + k, wrapping within the register address width.
- R4: For every stimulus register the engine first reads the register. It then writes back (~mask & current) | (mask & value) to the same address.
- R5: For every check register the engine reads the register and forms mask & (current ^ expected). A nonzero result is a failure. Bits where the mask is 0 never cause a failure.
- R6: Blocks are processed in the order stimulus block 0, check block 0, stimulus block 1, check block 1, and so on. When one part has more blocks than the other, its extra blocks still run in this order. Each block is finished before the next one starts.
- R7: On the first failure of a run the engine records the block index, the register address and the failing bits, and it keeps running. Later failures do not change the record. `fail` stays high until the next run starts.
- R8: A block count of zero, or a sequence count of zero, makes no register access. An image whose two block counts are both zero completes after exactly two memory reads.
- R9: `start` is accepted only while idle. It raises `busy`, and it clears `done` and the failure record. A `start` pulse during a run is ignored. At the end of a run `busy` falls and `done` rises, and `done` stays high until the next accepted start.
- R10: Memory read data is valid on the cycle after `mem_rd`. Register read data is valid on the cycle after `reg_rd`. A register read and a register write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle) |
| in_base | input | AW | Word address of the stimulus image part |
| out_base | input | AW | Word address of the check image part |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | DW | Memory read data, one cycle after the strobe |
| reg_rd | output | 1 | Device register read strobe |
| reg_wr | output | 1 | Device register write strobe |
| reg_addr | output | RAW | Device register address |
| reg_wdata | output | DW | Device register write data |
| reg_rdata | input | DW | Device register read data, one cycle after the strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete, held until the next start |
| fail | output | 1 | Sticky: at least one check failed in this run |
| fail_block | output | AW | Block index of the first failure |
| fail_addr | output | RAW | Register address of the first failure |
| fail_bits | output | DW | Failing bit pattern of the first failure |

## Verification
Some properties are checked by the assertions on every cycle. Every register write follows a read of the same address two cycles earlier. Reads and writes never overlap, and there is no bus traffic while idle. The failure record stays fixed once it is set and always holds a nonzero pattern, `done` excludes `busy`, and a run begins only on `start`. Other behaviour can only be shown by the bench scenarios, which compare final register contents and access counts against an independent model. These cover the correctness of the merged write data, the pointer-derived register counts, the interleaved block order when a check reads a register that a later stimulus block rewrites, the choice of first failure when several checks fail, and the skipping of empty blocks and sequences.

// File: rtl/tst_pkg.sv
// Shared definitions for the memory-image register test engine.
// Assumes: nothing beyond IEEE 1800-2017.
package tst_pkg;
    typedef enum logic [4:0] {
        S_IDLE, S_HI, S_HI_W, S_HO, S_HO_W, S_SEL, S_NEXT,
        S_BP, S_BP_W, S_BE, S_BE_W, S_BC, S_BC_W,
        S_SP, S_SP_W, S_SE, S_SE_W, S_SA, S_SA_W, S_NSEQ,
        S_RV, S_RV_W, S_RM, S_RM_W, S_RR, S_RR_W, S_ACT, S_DONE
    } walk_state_t;
endpackage

// File: rtl/tst_mask_unit.sv
// Per-bit merge and compare datapath.
// merged = (~mask & current) | (mask & value); diff = mask & (current ^ value).
// Assumes: purely combinational, all operands the same width.
module tst_mask_unit #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] val,
    input  logic [DW-1:0] msk,
    output logic [DW-1:0] merged,
    output logic [DW-1:0] diff
);
    // Bitwise multiplex and masked mismatch.
    always_comb begin
        merged = (~msk & cur) | (msk & val);
        diff   = msk & (cur ^ val);
    end
endmodule

// File: rtl/tst_fail_record.sv
// Holds the first mismatch of a run and a sticky fail flag.
// Assumes: clear and cmp_en never assert in the same cycle.
module tst_fail_record #(
    parameter int DW  = 32,
    parameter int AW  = 12,
    parameter int RAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           cmp_en,
    input  logic [DW-1:0]  diff,
    input  logic [AW-1:0]  blk_idx,
    input  logic [RAW-1:0] addr,
    output logic           fail,
    output logic [AW-1:0]  fail_block,
    output logic [RAW-1:0] fail_addr,
    output logic [DW-1:0]  fail_bits
);
    // Capture only when no failure has been recorded yet.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fail       <= 1'b0;
            fail_block <= '0;
            fail_addr  <= '0;
            fail_bits  <= '0;
        end else if (cmp_en && (diff != '0) && !fail) begin
            fail       <= 1'b1;
            fail_block <= blk_idx;
            fail_addr  <= addr;
            fail_bits  <= diff;
        end
    end
endmodule

// File: rtl/tst_walker.sv
// Walks the two linked image parts and sequences memory and register accesses.
// Every memory read takes two states (issue, capture). Every register is
// handled as value read, mask read, register read, then write or compare.
// Assumes: well-formed image, one-cycle memory and register read latency.
module tst_walker
    import tst_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 12,
    parameter int RAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [AW-1:0]  in_base,
    input  logic [AW-1:0]  out_base,
    output logic           mem_rd,
    output logic [AW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    output logic           reg_rd,
    output logic           reg_wr,
    output logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_rdata,
    output logic           busy,
    output logic           done,
    output logic           launch,
    output logic           cmp_en,
    output logic [AW-1:0]  blk_idx,
    output logic [DW-1:0]  cur,
    output logic [DW-1:0]  val,
    output logic [DW-1:0]  msk
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    walk_state_t    state;
    logic           phase;     // 0: stimulus part, 1: check part
    logic [AW-1:0]  b, nb_in, nb_out, blk_ptr, blk_end, ns, j;
    logic [AW-1:0]  seq_ptr, seq_end, nreg, k;
    logic [RAW-1:0] start_addr;
    logic [AW-1:0]  base, nb_max, span, nreg_calc;
    logic [AW-1:0]  word;

    // Derived values: active part base, longer block count, register count.
    always_comb begin
        base      = phase ? out_base : in_base;
        nb_max    = (nb_in > nb_out) ? nb_in : nb_out;
        span      = seq_end - seq_ptr - ONE;
        nreg_calc = span >> 1;
        word      = mem_rdata[AW-1:0];
    end

    assign busy     = (state != S_IDLE);
    assign launch   = (state == S_IDLE) && start;
    assign blk_idx  = b;
    assign reg_addr = start_addr + k[RAW-1:0];

    // Strobes and addresses decoded from the current state.
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        reg_rd   = 1'b0;
        reg_wr   = 1'b0;
        cmp_en   = 1'b0;
        case (state)
            S_HI:  begin mem_rd = 1'b1; mem_addr = in_base; end
            S_HO:  begin mem_rd = 1'b1; mem_addr = out_base; end
            S_BP:  begin mem_rd = 1'b1; mem_addr = base + ONE + b; end
            S_BE:  begin mem_rd = 1'b1; mem_addr = base + TWO + b; end
            S_BC:  begin mem_rd = 1'b1; mem_addr = base + blk_ptr; end
            S_SP:  begin mem_rd = 1'b1; mem_addr = base + blk_ptr + ONE + j; end
            S_SE:  begin
                mem_rd   = (j + ONE < ns);
                mem_addr = base + blk_ptr + TWO + j;
            end
            S_SA:  begin mem_rd = 1'b1; mem_addr = base + seq_ptr; end
            S_RV:  begin mem_rd = 1'b1; mem_addr = base + seq_ptr + ONE + k; end
            S_RM:  begin mem_rd = 1'b1; mem_addr = base + seq_ptr + ONE + nreg + k; end
            S_RR:  reg_rd = 1'b1;
            S_ACT: begin reg_wr = !phase; cmp_en = phase; end
            default: ;
        endcase
    end

    // Walk state, loop indices and captured words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            done       <= 1'b0;
            phase      <= 1'b0;
            b          <= '0;
            nb_in      <= '0;
            nb_out     <= '0;
            blk_ptr    <= '0;
            blk_end    <= '0;
            ns         <= '0;
            j          <= '0;
            seq_ptr    <= '0;
            seq_end    <= '0;
            nreg       <= '0;
            k          <= '0;
            start_addr <= '0;
            cur        <= '0;
            val        <= '0;
            msk        <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    done  <= 1'b0;
                    state <= S_HI;
                end
                S_HI:   state <= S_HI_W;
                S_HI_W: begin nb_in <= word; state <= S_HO; end
                S_HO:   state <= S_HO_W;
                S_HO_W: begin
                    nb_out <= word;
                    b      <= '0;
                    phase  <= 1'b0;
                    state  <= S_SEL;
                end
                S_SEL: begin
                    if (b >= nb_max)
                        state <= S_DONE;
                    else if ((!phase && b < nb_in) || (phase && b < nb_out))
                        state <= S_BP;
                    else
                        state <= S_NEXT;
                end
                S_NEXT: begin
                    if (!phase) phase <= 1'b1;
                    else begin
                        phase <= 1'b0;
                        b     <= b + ONE;
                    end
                    state <= S_SEL;
                end
                S_BP:   state <= S_BP_W;
                S_BP_W: begin blk_ptr <= word; state <= S_BE; end
                S_BE:   state <= S_BE_W;
                S_BE_W: begin blk_end <= word; state <= S_BC; end
                S_BC:   state <= S_BC_W;
                S_BC_W: begin
                    ns    <= word;
                    j     <= '0;
                    state <= (word == '0) ? S_NEXT : S_SP;
                end
                S_SP:   state <= S_SP_W;
                S_SP_W: begin seq_ptr <= word; state <= S_SE; end
                S_SE: begin
                    if (j + ONE < ns) state <= S_SE_W;
                    else begin
                        seq_end <= blk_end;
                        state   <= S_SA;
                    end
                end
                S_SE_W: begin seq_end <= word; state <= S_SA; end
                S_SA:   state <= S_SA_W;
                S_SA_W: begin
                    start_addr <= mem_rdata[RAW-1:0];
                    nreg       <= nreg_calc;
                    k          <= '0;
                    state      <= (nreg_calc == '0) ? S_NSEQ : S_RV;
                end
                S_NSEQ: begin
                    if (j + ONE < ns) begin
                        j     <= j + ONE;
                        state <= S_SP;
                    end else
                        state <= S_NEXT;
                end
                S_RV:   state <= S_RV_W;
                S_RV_W: begin val <= mem_rdata; state <= S_RM; end
                S_RM:   state <= S_RM_W;
                S_RM_W: begin msk <= mem_rdata; state <= S_RR; end
                S_RR:   state <= S_RR_W;
                S_RR_W: begin cur <= reg_rdata; state <= S_ACT; end
                S_ACT: begin
                    if (k + ONE < nreg) begin
                        k     <= k + ONE;
                        state <= S_RV;
                    end else
                        state <= S_NSEQ;
                end
                S_DONE: begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/reg_image_tester.sv
// Top of the memory-image register test engine: image walker, mask datapath
// and first-failure record.
// Assumes: synchronous memory and register port, each with one-cycle read latency.
module reg_image_tester #(
    parameter int DW  = 32,
    parameter int AW  = 12,
    parameter int RAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [AW-1:0]  in_base,
    input  logic [AW-1:0]  out_base,
    output logic           mem_rd,
    output logic [AW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    output logic           reg_rd,
    output logic           reg_wr,
    output logic [RAW-1:0] reg_addr,
    output logic [DW-1:0]  reg_wdata,
    input  logic [DW-1:0]  reg_rdata,
    output logic           busy,
    output logic           done,
    output logic           fail,
    output logic [AW-1:0]  fail_block,
    output logic [RAW-1:0] fail_addr,
    output logic [DW-1:0]  fail_bits
);
    logic          launch, cmp_en;
    logic [AW-1:0] blk_idx;
    logic [DW-1:0] cur, val, msk, diff;

    tst_walker #(.DW(DW), .AW(AW), .RAW(RAW)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_base(in_base), .out_base(out_base),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_rdata(reg_rdata), .busy(busy), .done(done),
        .launch(launch), .cmp_en(cmp_en), .blk_idx(blk_idx),
        .cur(cur), .val(val), .msk(msk)
    );

    tst_mask_unit #(.DW(DW)) u_mask (
        .cur(cur), .val(val), .msk(msk), .merged(reg_wdata), .diff(diff)
    );

    tst_fail_record #(.DW(DW), .AW(AW), .RAW(RAW)) u_rec (
        .clk(clk), .rst_n(rst_n), .clear(launch), .cmp_en(cmp_en),
        .diff(diff), .blk_idx(blk_idx), .addr(reg_addr),
        .fail(fail), .fail_block(fail_block), .fail_addr(fail_addr),
        .fail_bits(fail_bits)
    );
endmodule

// File: rtl/tst_checker.sv
// Port-level protocol checks for reg_image_tester, attached with bind.
// Assumes: synchronous active-low reset.
module tst_checker #(
    parameter int DW  = 32,
    parameter int AW  = 12,
    parameter int RAW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           mem_rd,
    input logic           reg_rd,
    input logic           reg_wr,
    input logic [RAW-1:0] reg_addr,
    input logic           busy,
    input logic           done,
    input logic           fail,
    input logic [AW-1:0]  fail_block,
    input logic [RAW-1:0] fail_addr,
    input logic [DW-1:0]  fail_bits
);
    assert_read_before_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> ($past(reg_rd, 2) && $past(reg_addr, 2) == reg_addr));

    assert_no_rw_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || reg_rd || reg_wr));

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_run_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_record_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && $past(fail)) |->
            ($stable(fail_block) && $stable(fail_addr) && $stable(fail_bits)));

    assert_fail_bits_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> (fail_bits != '0));
endmodule

bind reg_image_tester tst_checker #(.DW(DW), .AW(AW), .RAW(RAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .busy(busy), .done(done), .fail(fail), .fail_block(fail_block),
    .fail_addr(fail_addr), .fail_bits(fail_bits)
);

// File: tb/tb_reg_image_tester.sv
// Bench: behavioural memory and register file, image generator with a
// reference model of the stimulus and check rules.
module tb_reg_image_tester;
    localparam int DW = 32, AW = 12, RAW = 8;
    localparam int IN = 16, OUT = 2048;

    logic clk = 0, rst_n = 0, start = 0;
    logic [AW-1:0] in_base = AW'(IN), out_base = AW'(OUT);
    logic mem_rd, reg_rd, reg_wr, busy, done, fail;
    logic [AW-1:0] mem_addr, fail_block;
    logic [RAW-1:0] reg_addr, fail_addr;
    logic [DW-1:0] mem_rdata, reg_wdata, reg_rdata, fail_bits;

    reg_image_tester #(.DW(DW), .AW(AW), .RAW(RAW)) dut (.*);

    always #4 clk = ~clk;

    logic [31:0] mem [0:4095];
    logic [31:0] regs [0:255];
    logic [31:0] shadow [0:255];
    logic load_req = 0;
    int   seed_v = 0;
    int   cnt_rd = 0, cnt_wr = 0, cnt_mem = 0;
    int   n_chk = 0, n_fail = 0;
    int   exp_rd, exp_wr, opos;
    bit   exp_fail;
    int   exp_blk, exp_addr;
    logic [31:0] exp_bits;

    function automatic logic [31:0] hval(int i, int s);
        return (i * 32'h9E3779B1) ^ (s * 32'h85EBCA6B) ^ 32'h1234_5678;
    endfunction

    // Memory and register models, plus access counters.
    always @(posedge clk) begin
        if (mem_rd) begin mem_rdata <= mem[mem_addr]; cnt_mem <= cnt_mem + 1; end
        if (reg_rd) begin reg_rdata <= regs[reg_addr]; cnt_rd <= cnt_rd + 1; end
        if (reg_wr) begin regs[reg_addr] <= reg_wdata; cnt_wr <= cnt_wr + 1; end
        if (load_req) for (int i = 0; i < 256; i++) regs[i] <= hval(i, seed_v);
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rmask();
        int r = $urandom % 4;
        if (r == 0) return 32'hFFFF_FFFF;
        if (r == 1) return 32'h0;
        return $urandom;
    endfunction

    // Build the stimulus part (R2, R3 layout).
    task automatic gen_in(int nb, int maxns, int maxn, int span);
        int pos = 2 + nb;
        mem[IN] = nb;
        for (int b = 0; b < nb; b++) begin
            int ns = $urandom % (maxns + 1);
            int bh = pos;
            mem[IN+1+b] = pos;
            mem[IN+bh] = ns;
            pos = bh + 1 + ns;
            for (int j = 0; j < ns; j++) begin
                int n = $urandom % (maxn + 1);
                mem[IN+bh+1+j] = pos;
                mem[IN+pos] = $urandom % span;
                for (int k = 0; k < n; k++) begin
                    mem[IN+pos+1+k] = $urandom;
                    mem[IN+pos+1+n+k] = rmask();
                end
                pos += 1 + 2*n;
            end
        end
        mem[IN+1+nb] = pos;
    endtask

    // Reference: apply stimulus block b to the shadow registers (R3, R4).
    task automatic apply_in(int b);
        int bp = mem[IN+1+b], be = mem[IN+2+b], ns = mem[IN+bp];
        for (int j = 0; j < ns; j++) begin
            int sp = mem[IN+bp+1+j];
            int se = (j + 1 < ns) ? int'(mem[IN+bp+2+j]) : be;
            int a = mem[IN+sp];
            int n = (se - sp - 1) / 2;
            for (int k = 0; k < n; k++) begin
                logic [31:0] v = mem[IN+sp+1+k], m = mem[IN+sp+1+n+k];
                int r = (a + k) & 255;
                shadow[r] = (~m & shadow[r]) | (m & v);
                exp_rd++; exp_wr++;
            end
        end
    endtask

    // Build check block b against the current shadow; predict failures (R5, R7).
    task automatic gen_out_block(int b, int maxns, int maxn, int span, int fmode);
        int ns = $urandom % (maxns + 1);
        int bh = opos;
        mem[OUT+1+b] = opos;
        mem[OUT+bh] = ns;
        opos = bh + 1 + ns;
        for (int j = 0; j < ns; j++) begin
            int n = $urandom % (maxn + 1);
            int a = $urandom % span;
            mem[OUT+bh+1+j] = opos;
            mem[OUT+opos] = a;
            for (int k = 0; k < n; k++) begin
                int r = (a + k) & 255;
                logic [31:0] m = rmask(), fl = 0;
                if (fmode == 1) fl = ~m;
                else if (fmode == 2 && ($urandom % 4) == 0) fl = $urandom | 1;
                mem[OUT+opos+1+k] = shadow[r] ^ fl;
                mem[OUT+opos+1+n+k] = m;
                exp_rd++;
                if (((m & fl) != 0) && !exp_fail) begin
                    exp_fail = 1; exp_blk = b; exp_addr = r; exp_bits = m & fl;
                end
            end
            opos += 1 + 2*n;
        end
    endtask

    // Build a whole scenario with the interleaved reference order (R6).
    task automatic build(int nbi, int nbo, int maxns, int maxn, int span, int fmode, int s);
        seed_v = s;
        for (int i = 0; i < 256; i++) shadow[i] = hval(i, s);
        @(negedge clk) load_req = 1;
        @(negedge clk) load_req = 0;
        exp_rd = 0; exp_wr = 0; exp_fail = 0; exp_blk = 0; exp_addr = 0; exp_bits = 0;
        gen_in(nbi, maxns, maxn, span);
        mem[OUT] = nbo;
        opos = 2 + nbo;
        for (int b = 0; b < ((nbi > nbo) ? nbi : nbo); b++) begin
            if (b < nbi) apply_in(b);
            if (b < nbo) gen_out_block(b, maxns, maxn, span, fmode);
        end
        mem[OUT+1+nbo] = opos;
    endtask

    // Start a run, optionally re-pulse start mid-run, and check everything.
    task automatic run_check(string tag, bit repulse, int exp_mem);
        int r0 = cnt_rd, w0 = cnt_wr, m0 = cnt_mem, t = 0;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        check(busy == 1, "R9", {tag, " busy after start"}, 32'(busy), 1);
        check(done == 0, "R9", {tag, " done cleared"}, 32'(done), 0);
        if (repulse) begin
            repeat (10) @(negedge clk);
            start = 1;
            @(negedge clk) start = 0;
        end
        while (!done && t < 20000) begin @(negedge clk); t++; end
        check(done == 1, "R9", {tag, " done reached"}, 32'(done), 1);
        check(busy == 0, "R9", {tag, " idle at end"}, 32'(busy), 0);
        check(fail == exp_fail, "R5", {tag, " fail flag"}, 32'(fail), 32'(exp_fail));
        if (exp_fail) begin
            check(fail_block == AW'(exp_blk), "R7", {tag, " fail block"}, 32'(fail_block), exp_blk);
            check(fail_addr == RAW'(exp_addr), "R7", {tag, " fail addr"}, 32'(fail_addr), exp_addr);
            check(fail_bits == exp_bits, "R7", {tag, " fail bits"}, fail_bits, exp_bits);
        end
        check(cnt_rd - r0 == exp_rd, "R3", {tag, " register reads"}, cnt_rd - r0, exp_rd);
        check(cnt_wr - w0 == exp_wr, "R4", {tag, " register writes"}, cnt_wr - w0, exp_wr);
        if (exp_mem >= 0)
            check(cnt_mem - m0 == exp_mem, "R8", {tag, " memory reads"}, cnt_mem - m0, exp_mem);
        begin
            int bad = -1;
            for (int i = 0; i < 256; i++) if (bad < 0 && regs[i] !== shadow[i]) bad = i;
            check(bad < 0, "R4", {tag, " register file"},
                  (bad < 0) ? 0 : regs[bad], (bad < 0) ? 0 : shadow[bad]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) mem[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !done && !fail, "R1", "reset state", {busy, done, fail}, 0);
        check(!mem_rd && !reg_rd && !reg_wr, "R1", "no access after reset",
              {mem_rd, reg_rd, reg_wr}, 0);

        // R8: both parts empty, exactly the two header reads.
        build(0, 0, 0, 0, 256, 0, 1);
        run_check("empty_R8", 0, 2);
        // R8: blocks whose sequence counts are zero.
        build(3, 2, 0, 0, 256, 0, 2);
        run_check("noseq_R8", 0, -1);
        // R5: mismatches only on masked-off bits never fail.
        build(2, 3, 3, 3, 256, 1, 3);
        run_check("dontcare_R5", 0, -1);
        // R6: narrow address span forces check/stimulus overlap.
        for (int i = 0; i < 6; i++) begin
            build(3, 3, 2, 3, 4, 2, 10 + i);
            run_check("order_R6", 0, -1);
        end
        // R9: start pulse during a run is ignored.
        build(3, 3, 3, 3, 8, 2, 30);
        run_check("restart_R9", 1, -1);
        // Random mix, including unequal block counts (R2, R10).
        for (int i = 0; i < 25; i++) begin
            build($urandom % 4, $urandom % 4, 3, 4, (i % 2) ? 6 : 256, 2, 100 + i);
            run_check("random_R2_R10", 0, -1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule